// File: doc/BRIEF.md
# Parallel SCSI Initiator Byte Transfer Engine

This block moves a programmed number of bytes between an initiator and a target on a parallel SCSI bus. It does this one REQ/ACK handshake at a time and works in either direction. When a transfer starts, the block records the MSG, C/D and I/O lines as a phase reference. For each byte it waits for the target to raise REQ and confirms the phase still matches the reference. In the receive direction it then lets the data lines settle and samples them. In the send direction the byte is already on the bus before REQ arrives. The block then raises ACK, waits for REQ to fall, drops ACK, checks the phase again and only then counts the byte.

A transfer can stop early for one of three reasons: a REQ wait runs out of time, the bus reset line is seen while waiting, or the phase moves away from the reference. In each case the status reports how many bytes completed and why the transfer ended. A fixed-length pause can be placed in front of one chosen byte index. Bytes to send are pulled from an upstream source with a pop strobe, and received bytes are handed downstream with a valid strobe.

Top module: `scsi_init_xfer`

## Requirements
- R1: While rstN is low and in the first cycle after it, ackOut, busy, doneOut and rxValid are all 0.
- R2: The block records {msgIn, cdIn, ioIn} in the clock edge that accepts start. If REQ is seen while the phase lines differ from that record, the transfer ends with endCause 2 (phase) and doneCount equal to the bytes completed so far. ACK is not raised for that REQ.
- R3: In the receive direction (dirIn = 1), ACK rises exactly SETTLE_CYC cycles later than it would in the send direction. Received bytes appear on rxData with a one-cycle rxValid, in bus order, one per counted byte.
- R4: In the send direction (dirIn = 0), byte i of the upstream stream is already on busDataOut when REQ for byte i arrives. It stays stable while ACK is high, and txPop pulses once per byte fetched.
- R5: When the block is ready and REQ is already high, ACK rises 2 cycles after REQ in the send direction. ACK falls in the cycle after REQ is seen low.
- R6: After REQ drops, the phase lines are compared again. On a mismatch the transfer ends with endCause 2, the byte in flight is not counted, and no rxValid is given for it.
- R7: When the byte index equals pauseAt, the block waits an extra PAUSE_CYC cycles before it accepts REQ for that byte.
- R8: If REQ does not rise within TIMEOUT_CYC cycles of the wait starting, the transfer ends with endCause 1 (timeout). The done pulse comes TIMEOUT_CYC+1 cycles after the block enters the byte preparation step.
- R9: A high busRstIn during a REQ wait ends the transfer in the next state update with endCause 3 (reset) and ACK low.
- R10: A transfer that completes gives a one-cycle doneOut with endCause 0 and doneCount equal to xferLen. A start with xferLen = 0 gives doneOut with doneCount 0 in the next cycle.
- R11: busDataOe is 1 exactly when busy is 1 and ioIn is 0.
- R12: A start pulse while busy is ignored. The running transfer keeps its length, and only one doneOut results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| dirIn | input | 1 | 1 = receive from target, 0 = send to target |
| xferLen | input | CW | Number of bytes to move |
| pauseAt | input | CW | Byte index that is preceded by the pause |
| txData | input | DW | Next byte to send, advanced by txPop |
| txPop | output | 1 | Current txData has been taken |
| rxData | output | DW | Received byte |
| rxValid | output | 1 | rxData holds a new byte |
| doneOut | output | 1 | One-cycle end-of-transfer pulse |
| doneCount | output | CW | Bytes completed, valid with doneOut |
| endCause | output | 2 | 0 done, 1 timeout, 2 phase, 3 reset |
| busy | output | 1 | Transfer in progress |
| reqIn | input | 1 | REQ from target, active high |
| ackOut | output | 1 | ACK to target, active high |
| busRstIn | input | 1 | Bus RST line, active high |
| msgIn | input | 1 | MSG line |
| cdIn | input | 1 | C/D line |
| ioIn | input | 1 | I/O line |
| busDataIn | input | DW | Data lines as received |
| busDataOut | output | DW | Data lines to drive |
| busDataOe | output | 1 | Drive enable for busDataOut |

## Verification
The bench builds the block with SETTLE_CYC = 3, PAUSE_CYC = 5 and TIMEOUT_CYC = 60. These short values let the bench reach the multi-second REQ timeout within a few dozen cycles, and they let it check the settle and pause delays as exact ACK latencies. A target model drives REQ, the data lines and the phase lines. It can stall, pulse bus reset, or change the phase either before REQ or while ACK is high, at any chosen byte index.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

  typedef enum logic [1:0] {
    END_OK      = 2'd0,
    END_TIMEOUT = 2'd1,
    END_PHASE   = 2'd2,
    END_RESET   = 2'd3
  } endCause_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic      capStart;  // record phase, length, pause index, direction
    logic      clrTimer;  // restart the shared wait timer
    logic      loadTx;    // take txData onto the data register
    logic      capRx;     // sample busDataIn into the data register
    logic      incIdx;    // byte completed
    logic      finish;    // transfer ends this cycle
    endCause_t cause;     // reason, valid with finish
  } strobe_t;

endpackage

// File: rtl/scsi_xfer_dpath.sv
module scsi_xfer_dpath
  import scsi_xfer_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [CW-1:0] xferLen,
  input  logic [CW-1:0] pauseAt,
  input  logic          dirIn,
  input  logic [2:0]    phaseNow,
  input  logic [DW-1:0] txData,
  input  logic [DW-1:0] busDataIn,
  output logic [2:0]    phaseRef,
  output logic [CW-1:0] lenReg,
  output logic [CW-1:0] pauseReg,
  output logic          dirReg,
  output logic [CW-1:0] byteIdx,
  output logic [TW-1:0] timer,
  output logic [DW-1:0] dataReg,
  output logic          rxValid,
  output logic          doneOut,
  output logic [CW-1:0] doneCount,
  output endCause_t     endCause
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseRef <= '0;
      lenReg   <= '0;
      pauseReg <= '0;
      dirReg   <= 1'b0;
      byteIdx  <= '0;
    end else if (st.capStart) begin
      phaseRef <= phaseNow;
      lenReg   <= xferLen;
      pauseReg <= pauseAt;
      dirReg   <= dirIn;
      byteIdx  <= '0;
    end else if (st.incIdx) begin
      byteIdx  <= byteIdx + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clrTimer) timer <= '0;
    else if (timer != '1)     timer <= timer + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dataReg <= '0;
    else if (st.loadTx) dataReg <= txData;
    else if (st.capRx)  dataReg <= busDataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid   <= 1'b0;
      doneOut   <= 1'b0;
      doneCount <= '0;
      endCause  <= END_OK;
    end else begin
      rxValid <= st.incIdx & dirReg;
      doneOut <= st.finish;
      if (st.finish) begin
        doneCount <= st.capStart ? '0 : byteIdx + CW'(st.incIdx);
        endCause  <= st.cause;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> doneCount <= lenReg); // R10

  AST_RX_NOT_IN_SEND: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> dirReg); // R3

endmodule

// File: rtl/scsi_xfer_ctrl.sv
module scsi_xfer_ctrl
  import scsi_xfer_pkg::*;
#(
  parameter int CW          = 8,
  parameter int TW          = 8,
  parameter int SETTLE_CYC  = 3,
  parameter int PAUSE_CYC   = 5,
  parameter int TIMEOUT_CYC = 60
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] xferLen,
  input  logic          reqIn,
  input  logic          busRstIn,
  input  logic [2:0]    phaseNow,
  input  logic [2:0]    phaseRef,
  input  logic [CW-1:0] lenReg,
  input  logic [CW-1:0] pauseReg,
  input  logic          dirReg,
  input  logic [CW-1:0] byteIdx,
  input  logic [TW-1:0] timer,
  output strobe_t       st,
  output logic          ackOut,
  output logic          busy,
  output logic          txPop
);

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_PAUSE, S_WREQ, S_SETTLE, S_ACK
  } state_t;

  state_t state, nxt;

  logic phaseBad, lastByte, toHit;
  assign phaseBad = (phaseNow != phaseRef);
  assign lastByte = (byteIdx == lenReg - CW'(1));
  assign toHit    = (timer == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        st.capStart = 1'b1;
        if (xferLen == '0) st.finish = 1'b1;
        else               nxt = S_PREP;
      end
      S_PREP: begin
        st.clrTimer = 1'b1;
        if (byteIdx == pauseReg) nxt = S_PAUSE;
        else begin
          nxt       = S_WREQ;
          st.loadTx = ~dirReg;
        end
      end
      S_PAUSE: if (timer == TW'(PAUSE_CYC - 1)) begin
        nxt         = S_WREQ;
        st.clrTimer = 1'b1;
        st.loadTx   = ~dirReg;
      end
      S_WREQ: begin
        if (busRstIn) begin
          st.finish = 1'b1; st.cause = END_RESET;
        end else if (reqIn) begin
          if (phaseBad) begin
            st.finish = 1'b1; st.cause = END_PHASE;
          end else begin
            st.clrTimer = 1'b1;
            nxt = dirReg ? S_SETTLE : S_ACK;
          end
        end else if (toHit) begin
          st.finish = 1'b1; st.cause = END_TIMEOUT;
        end
      end
      S_SETTLE: if (timer == TW'(SETTLE_CYC - 1)) begin
        st.capRx    = 1'b1;
        st.clrTimer = 1'b1;
        nxt         = S_ACK;
      end
      S_ACK: begin
        if (busRstIn) begin
          st.finish = 1'b1; st.cause = END_RESET;
        end else if (!reqIn) begin
          if (phaseBad) begin
            st.finish = 1'b1; st.cause = END_PHASE;
          end else begin
            st.incIdx = 1'b1;
            if (lastByte) st.finish = 1'b1;
            else          nxt = S_PREP;
          end
        end else if (toHit) begin
          st.finish = 1'b1; st.cause = END_TIMEOUT;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (st.finish) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign ackOut = (state == S_ACK);
  assign busy   = (state != S_IDLE);
  assign txPop  = st.loadTx;

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(reqIn)); // R5

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut && !reqIn |=> !ackOut); // R5

  AST_RST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WREQ || ackOut) && busRstIn |=> !busy && !ackOut); // R9

  AST_START_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R12

endmodule

// File: rtl/scsi_init_xfer.sv
module scsi_init_xfer
  import scsi_xfer_pkg::*;
#(
  parameter int CW          = 8,
  parameter int DW          = 8,
  parameter int SETTLE_CYC  = 20,
  parameter int PAUSE_CYC   = 5000,
  parameter int TIMEOUT_CYC = 150_000_000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          dirIn,
  input  logic [CW-1:0] xferLen,
  input  logic [CW-1:0] pauseAt,
  input  logic [DW-1:0] txData,
  output logic          txPop,
  output logic [DW-1:0] rxData,
  output logic          rxValid,
  output logic          doneOut,
  output logic [CW-1:0] doneCount,
  output logic [1:0]    endCause,
  output logic          busy,
  input  logic          reqIn,
  output logic          ackOut,
  input  logic          busRstIn,
  input  logic          msgIn,
  input  logic          cdIn,
  input  logic          ioIn,
  input  logic [DW-1:0] busDataIn,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe
);

  localparam int MAX_A  = (SETTLE_CYC > PAUSE_CYC) ? SETTLE_CYC : PAUSE_CYC;
  localparam int MAX_W  = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
  localparam int TW     = $clog2(MAX_W + 1);

  strobe_t       st;
  logic [2:0]    phaseNow, phaseRef;
  logic [CW-1:0] lenReg, pauseReg, byteIdx;
  logic          dirReg;
  logic [TW-1:0] timer;
  logic [DW-1:0] dataReg;
  endCause_t     causeReg;

  assign phaseNow = {msgIn, cdIn, ioIn};

  scsi_xfer_ctrl #(
    .CW(CW), .TW(TW), .SETTLE_CYC(SETTLE_CYC),
    .PAUSE_CYC(PAUSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen),
    .reqIn(reqIn), .busRstIn(busRstIn), .phaseNow(phaseNow),
    .phaseRef(phaseRef), .lenReg(lenReg), .pauseReg(pauseReg),
    .dirReg(dirReg), .byteIdx(byteIdx), .timer(timer),
    .st(st), .ackOut(ackOut), .busy(busy), .txPop(txPop)
  );

  scsi_xfer_dpath #(.CW(CW), .DW(DW), .TW(TW)) i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .xferLen(xferLen),
    .pauseAt(pauseAt), .dirIn(dirIn), .phaseNow(phaseNow),
    .txData(txData), .busDataIn(busDataIn), .phaseRef(phaseRef),
    .lenReg(lenReg), .pauseReg(pauseReg), .dirReg(dirReg),
    .byteIdx(byteIdx), .timer(timer), .dataReg(dataReg),
    .rxValid(rxValid), .doneOut(doneOut), .doneCount(doneCount),
    .endCause(causeReg)
  );

  assign endCause   = causeReg;
  assign rxData     = dataReg;
  assign busDataOut = dataReg;
  assign busDataOe  = busy & ~ioIn;

  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut && $past(ackOut) && busDataOe |-> $stable(busDataOut)); // R4

endmodule

// File: tb/test_scsi_init_xfer.sv
`timescale 1ns/1ps
module test_scsi_init_xfer;

  localparam int CW = 8, DW = 8, SET = 3, PAU = 5, TO = 60;
  localparam int NOPAUSE = 255;

  logic clk = 0, rstN = 0, start = 0, dirIn = 0;
  logic [CW-1:0] xferLen = '0, pauseAt = '1;
  logic [DW-1:0] txData, rxData, busDataIn = '0, busDataOut;
  logic txPop, rxValid, doneOut, busy, ackOut, busDataOe;
  logic [CW-1:0] doneCount;
  logic [1:0] endCause;
  logic reqIn = 0, busRstIn = 0, msgIn = 0, cdIn = 0, ioIn = 0;
  logic [7:0] txCnt = '0;

  int checks = 0, errors = 0, cyc = 0;
  int rxQ[$], doneCntQ[$], doneCauseQ[$];

  always #10 clk = ~clk;

  scsi_init_xfer #(.CW(CW), .DW(DW), .SETTLE_CYC(SET), .PAUSE_CYC(PAU),
                   .TIMEOUT_CYC(TO)) i_scsi_init_xfer (
    .clk(clk), .rstN(rstN), .start(start), .dirIn(dirIn), .xferLen(xferLen),
    .pauseAt(pauseAt), .txData(txData), .txPop(txPop), .rxData(rxData),
    .rxValid(rxValid), .doneOut(doneOut), .doneCount(doneCount),
    .endCause(endCause), .busy(busy), .reqIn(reqIn), .ackOut(ackOut),
    .busRstIn(busRstIn), .msgIn(msgIn), .cdIn(cdIn), .ioIn(ioIn),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(8'h3C + i * 29);
  endfunction

  // upstream byte source: restarts when a transfer is accepted
  always @(posedge clk)
    if (start && !busy) txCnt <= '0;
    else if (txPop)     txCnt <= txCnt + 8'd1;
  assign txData = pat(int'(txCnt));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitors: pop expected items as the design produces them
  always @(negedge clk) if (rstN) begin
    if (rxValid) begin
      if (rxQ.size() == 0) check("R6 unexpected rxValid", 1, 0);
      else check("R3 rx byte", int'(rxData), rxQ.pop_front());
    end
    if (doneOut) begin
      if (doneCntQ.size() == 0) check("R12 unexpected doneOut", 1, 0);
      else begin
        check("R10 doneCount", int'(doneCount), doneCntQ.pop_front());
        check("R2 endCause", int'(endCause), doneCauseQ.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // mode: 0 normal, 1 stall, 2 bus reset, 3 phase change before REQ,
  //       4 phase change while ACK high, 5 extra start while busy
  task automatic runXfer(input bit rx, input int len, input int pz,
                         input int mode, input int at);
    int k;
    int expCnt, expCause;
    expCnt = (mode == 0 || mode == 5) ? len : at;
    expCause = (mode == 1) ? 1 : (mode == 2) ? 3 : (mode == 3 || mode == 4) ? 2 : 0;
    doneCntQ.push_back(expCnt);
    doneCauseQ.push_back(expCause);
    ioIn = rx; msgIn = 0; cdIn = 0;
    @(negedge clk);
    start = 1; dirIn = rx; xferLen = CW'(len); pauseAt = CW'(pz);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < len; i++) begin
      k = 0;
      if ((mode == 1 || mode == 2 || mode == 3) && i == at) begin
        if (mode == 2) busRstIn = 1;
        if (mode == 3) begin msgIn = 1; reqIn = 1; end
        do begin @(negedge clk); k++; end while (!doneOut && k < 2000);
        if (mode == 1) check("R8 timeout latency", k, TO + 1);
        if (mode == 2) check("R9 reset latency", k, 2);
        if (mode == 3) check("R2 phase abort latency", k, 2);
        check("R9 ack low after abort", int'(ackOut), 0);
        busRstIn = 0; reqIn = 0; msgIn = 0;
        break;
      end
      if (rx) begin
        busDataIn = pat(i) ^ 8'hFF;
        if (!(mode == 4 && i == at)) rxQ.push_back(int'(pat(i) ^ 8'hFF));
      end
      if (mode == 5 && i == 1) begin start = 1; xferLen = 8'd1; end
      reqIn = 1;
      do begin @(negedge clk); start = 0; k++; end while (!ackOut && k < 2000);
      if (rx) check("R3 ack latency with settle", k, 2 + SET + ((i == pz) ? PAU : 0));
      else    check("R5 ack latency", k, 2 + ((i == pz) ? PAU : 0));
      if (i == pz) check("R7 pause applied", k, 2 + (rx ? SET : 0) + PAU);
      if (!rx) check("R4 tx byte on bus", int'(busDataOut), int'(pat(i)));
      check("R11 output enable", int'(busDataOe), rx ? 0 : 1);
      @(negedge clk);
      if (!rx) check("R4 tx byte held", int'(busDataOut), int'(pat(i)));
      if (mode == 4 && i == at) msgIn = 1;
      reqIn = 0;
      @(negedge clk);
      check("R5 ack release", int'(ackOut), 0);
      if (mode == 4 && i == at) break;
    end
    k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    msgIn = 0;
    check("R11 oe idle", int'(busDataOe), 0);
    check("R6 rx queue drained", rxQ.size(), 0);
    check("R10 done seen", doneCntQ.size(), 0);
    rxQ.delete(); doneCntQ.delete(); doneCauseQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack in reset", int'(ackOut), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(doneOut), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 rxValid after reset", int'(rxValid), 0);
    check("R1 busy after reset", int'(busy), 0);

    runXfer(0, 4, NOPAUSE, 0, 0);   // R4 R5 R10 send
    runXfer(1, 5, 2, 0, 0);         // R3 R7 receive with pause
    runXfer(0, 3, 0, 0, 0);         // R7 pause before first byte
    runXfer(1, 4, NOPAUSE, 1, 2);   // R8 timeout mid-stream
    runXfer(0, 2, NOPAUSE, 1, 0);   // R8 timeout on first byte
    runXfer(0, 3, NOPAUSE, 2, 1);   // R9 bus reset
    runXfer(1, 5, NOPAUSE, 3, 3);   // R2 phase change before REQ
    runXfer(0, 3, NOPAUSE, 4, 1);   // R6 phase change during ACK
    runXfer(1, 2, NOPAUSE, 4, 0);   // R6 receive, byte not delivered
    runXfer(0, 0, NOPAUSE, 0, 0);   // R10 zero length
    runXfer(0, 3, NOPAUSE, 5, 0);   // R12 start while busy ignored

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule